// File: doc/BRIEF.md
# Multi-channel counter interrupt and status controller

This block is the shared control and status logic that sits beside a bank of quadrature counter cores. For every channel it holds a small control byte. That byte gates the channel's A/B count inputs, carries an active-low preset-on-index enable, and selects which of four counter events may flag the channel. Events selected on a channel whose mask bit is set are latched into a sticky pending byte, and any pending bit raises one active-high interrupt line.

A global command register controls the whole bank. One command puts the bank in a reset condition: it pulses a clear to all counters, stops counting and disarms flagging. A second command arms flagging, starts counting and wipes all pending bits in one stroke. The block also holds a per-channel cable fault detection enable, which is active low, and merges it with the raw cable status for readback. It also presents the live index input levels.

Software reaches the block through a plain synchronous write port and a combinational read port. The channel control bytes occupy addresses 0 to NUM_CH-1. The remaining registers follow directly after them.

Top module: `qcnt_irq_ctrl`

## Requirements
- R1: After reset, the block is in this state:
  - every channel control byte reads 0x00
  - the channel mask reads 0x00
  - the pending byte reads 0x00
  - the command readback is 0x00
  - `irq`, `countRun` and `counterClear` are low
  - the cable enable register holds all ones, so the cable readback is 0xFF whatever `cableOk` is.
- R2: A write to address n (n < NUM_CH) stores data bits [4:0] in channel n's control byte. A read of that address returns them with bits [7:5] as zero. Bit 0 drives `abEnable[n]` and bit 1 drives `presetIdxN[n]` unchanged.
- R3: Bits [4:3] of a channel's control byte choose its flag source:
  - 0 selects carry
  - 1 selects compare
  - 2 selects carry or borrow
  - 3 selects index

  An event that is not selected never sets the channel's pending bit.
- R4: Bit n of the pending byte (read at address NUM_CH) belongs to channel n. It is set one clock after a qualifying event and stays set until the arm command is written.
- R5: The mask register (address NUM_CH+2) gates each channel separately. A channel whose mask bit is 0 never gains a pending bit, and a mask of 0x00 blocks all channels.
- R6: Writing 0x01 to the command register (address NUM_CH+1) has these effects:
  - `counterClear` goes high for exactly one cycle
  - `countRun` goes low
  - flagging is disarmed, so later events are ignored
  - bits that are already pending are kept
  - the command readback becomes 0x00
- R7: Writing 0x04 to the command register has these effects:
  - `countRun` goes high
  - flagging is armed
  - the command readback becomes 0x04
  - every pending bit is cleared

  If flagging was already armed, an event that qualifies in the same cycle as this write still sets its pending bit. If flagging was not armed, such an event is ignored.
- R8: Any command value other than 0x01 and 0x04 leaves the arm state, `countRun`, `counterClear` and the pending byte unchanged.
- R9: In the cable register (address NUM_CH+4), a written 0 in bit n enables fault detection for channel n, and `cableDetEn[n]` is the inverse of that bit. Readback bit n is 0 only when detection is enabled and `cableOk[n]` is low.
- R10: A read of address NUM_CH+3 returns the live `indexLevel` inputs, one bit per channel, with no clock delay.
- R11: `irq` is high exactly when at least one pending bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | 8 | Write data |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | 8 | Combinational read data |
| evCarry | input | NUM_CH | Carry pulses from the counter cores |
| evBorrow | input | NUM_CH | Borrow pulses from the counter cores |
| evCompare | input | NUM_CH | Compare-match pulses from the counter cores |
| evIndex | input | NUM_CH | Index pulses from the counter cores |
| indexLevel | input | NUM_CH | Live index input levels |
| cableOk | input | NUM_CH | Raw cable status, 1 = healthy |
| abEnable | output | NUM_CH | Per-channel A/B input enable |
| presetIdxN | output | NUM_CH | Per-channel preset-on-index enable, active low |
| cableDetEn | output | NUM_CH | Per-channel cable fault detection enable, active high |
| countRun | output | 1 | Counters running |
| counterClear | output | 1 | One-cycle clear to all counters |
| irq | output | 1 | Interrupt, active high |

## Verification
The embedded properties take the following for granted:
- the event inputs, `cableOk` and `indexLevel` are synchronous to `clk`
- the write port carries known values whenever `wrEn` is high
- an event pulse is counted once per cycle in which it is high

The stimulus drives every input on the falling edge, holds each event for exactly one cycle, and only asserts `wrEn` with a defined address and data. Events are sampled one clock later, and combinational readback is sampled shortly after the address changes.

// File: rtl/qcnt_irq_pkg.sv
package qcnt_irq_pkg;

  localparam int DATA_W = 8;

  // Register offsets counted from NUM_CH (channel control bytes sit below)
  localparam int OFS_STAT  = 0;
  localparam int OFS_CMD   = 1;
  localparam int OFS_MASK  = 2;
  localparam int OFS_LVL   = 3;
  localparam int OFS_CABLE = 4;
  localparam int NUM_OFS   = 5;

  localparam logic [DATA_W-1:0] CMD_RESET = 8'h01;
  localparam logic [DATA_W-1:0] CMD_ARM   = 8'h04;

  typedef enum logic [1:0] {
    TRIG_CARRY   = 2'd0,
    TRIG_COMPARE = 2'd1,
    TRIG_EITHER  = 2'd2,
    TRIG_INDEX   = 2'd3
  } trigSel_t;

  typedef struct packed {
    logic              iocWr;
    logic              maskWr;
    logic              cableWr;
    logic              cmdReset;
    logic              cmdArm;
    logic [DATA_W-1:0] wdata;
  } ctlStrobe_t;

endpackage

// File: rtl/qcnt_irq_evsel.sv
module qcnt_irq_evsel
  import qcnt_irq_pkg::*;
(
  input  logic [1:0] trig,
  input  logic       carry,
  input  logic       borrow,
  input  logic       compare,
  input  logic       index,
  output logic       hit
);

  always_comb begin
    unique case (trigSel_t'(trig))
      TRIG_CARRY:   hit = carry;
      TRIG_COMPARE: hit = compare;
      TRIG_EITHER:  hit = carry | borrow;
      TRIG_INDEX:   hit = index;
      default:      hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/qcnt_irq_ctl.sv
module qcnt_irq_ctl
  import qcnt_irq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 4,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
)(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output ctlStrobe_t        strb,
  output logic [CH_W-1:0]   chanIdx
);

  localparam logic [ADDR_W-1:0] ADR_CMD   = ADDR_W'(NUM_CH + OFS_CMD);
  localparam logic [ADDR_W-1:0] ADR_MASK  = ADDR_W'(NUM_CH + OFS_MASK);
  localparam logic [ADDR_W-1:0] ADR_CABLE = ADDR_W'(NUM_CH + OFS_CABLE);
  localparam logic [ADDR_W-1:0] ADR_CH_END = ADDR_W'(NUM_CH);

  logic isCmd;

  assign isCmd   = wrEn && (wrAddr == ADR_CMD);
  assign chanIdx = CH_W'(wrAddr);

  always_comb begin
    strb          = '0;
    strb.wdata    = wrData;
    strb.iocWr    = wrEn && (wrAddr < ADR_CH_END);
    strb.maskWr   = wrEn && (wrAddr == ADR_MASK);
    strb.cableWr  = wrEn && (wrAddr == ADR_CABLE);
    strb.cmdReset = isCmd && (wrData == CMD_RESET);
    strb.cmdArm   = isCmd && (wrData == CMD_ARM);
  end

endmodule

// File: rtl/qcnt_irq_dp.sv
module qcnt_irq_dp
  import qcnt_irq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 4,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [CH_W-1:0]   chanIdx,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [NUM_CH-1:0] evCarry,
  input  logic [NUM_CH-1:0] evBorrow,
  input  logic [NUM_CH-1:0] evCompare,
  input  logic [NUM_CH-1:0] evIndex,
  input  logic [NUM_CH-1:0] indexLevel,
  input  logic [NUM_CH-1:0] cableOk,
  output logic [NUM_CH-1:0] abEnable,
  output logic [NUM_CH-1:0] presetIdxN,
  output logic [NUM_CH-1:0] cableDetEn,
  output logic              countRun,
  output logic              counterClear,
  output logic              irq
);

  localparam int IOC_W = 5;
  localparam logic [ADDR_W-1:0] ADR_STAT  = ADDR_W'(NUM_CH + OFS_STAT);
  localparam logic [ADDR_W-1:0] ADR_CMD   = ADDR_W'(NUM_CH + OFS_CMD);
  localparam logic [ADDR_W-1:0] ADR_MASK  = ADDR_W'(NUM_CH + OFS_MASK);
  localparam logic [ADDR_W-1:0] ADR_LVL   = ADDR_W'(NUM_CH + OFS_LVL);
  localparam logic [ADDR_W-1:0] ADR_CABLE = ADDR_W'(NUM_CH + OFS_CABLE);

  logic [IOC_W-1:0]  iocReg [NUM_CH];
  logic [NUM_CH-1:0] maskReg;
  logic [NUM_CH-1:0] cableReg;
  logic [NUM_CH-1:0] pending;
  logic [NUM_CH-1:0] rawHit;
  logic [NUM_CH-1:0] hit;
  logic              armed;
  logic              clrPulse;
  logic [DATA_W-IOC_W-1:0] unusedWdataHi;

  assign unusedWdataHi = strb.wdata[DATA_W-1:IOC_W];

  // Per-channel control bytes and trigger selection
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        iocReg[i] <= '0;
      else if (strb.iocWr && (chanIdx == CH_W'(i)))
        iocReg[i] <= strb.wdata[IOC_W-1:0];
    end

    assign abEnable[i]   = iocReg[i][0];
    assign presetIdxN[i] = iocReg[i][1];

    qcnt_irq_evsel u_sel (
      .trig    (iocReg[i][4:3]),
      .carry   (evCarry[i]),
      .borrow  (evBorrow[i]),
      .compare (evCompare[i]),
      .index   (evIndex[i]),
      .hit     (rawHit[i])
    );
  end

  assign hit = rawHit & maskReg & {NUM_CH{armed}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg  <= '0;
      cableReg <= '1;
    end else begin
      if (strb.maskWr)  maskReg  <= strb.wdata[NUM_CH-1:0];
      if (strb.cableWr) cableReg <= strb.wdata[NUM_CH-1:0];
    end
  end

  // Global command state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed    <= 1'b0;
      clrPulse <= 1'b0;
    end else begin
      clrPulse <= strb.cmdReset;
      if (strb.cmdReset)    armed <= 1'b0;
      else if (strb.cmdArm) armed <= 1'b1;
    end
  end

  // Sticky pending byte; an arm command wipes it but a same-cycle hit survives
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      pending <= '0;
    else if (strb.cmdArm)
      pending <= hit;
    else
      pending <= pending | hit;
  end

  assign countRun     = armed;
  assign counterClear = clrPulse;
  assign irq          = |pending;
  assign cableDetEn   = ~cableReg;

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (rdAddr == ADDR_W'(i)) rdData = DATA_W'(iocReg[i]);
    if (rdAddr == ADR_STAT)  rdData = DATA_W'(pending);
    if (rdAddr == ADR_CMD)   rdData = armed ? CMD_ARM : '0;
    if (rdAddr == ADR_MASK)  rdData = DATA_W'(maskReg);
    if (rdAddr == ADR_LVL)   rdData = DATA_W'(indexLevel);
    if (rdAddr == ADR_CABLE) rdData = DATA_W'(cableReg | cableOk);
  end

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cmdArm |=> ((~pending & $past(pending)) == '0)); // R4

  AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rstN)
    !maskReg[0] |=> !(pending[0] && !$past(pending[0]))); // R5

  AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!armed && !strb.cmdArm) |=> ((pending & ~$past(pending)) == '0)); // R6

  AST_CLR_LEAVES_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    counterClear |-> !countRun); // R6

  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.cmdArm |=> ((pending & ~$past(hit)) == '0)); // R7

endmodule

// File: rtl/qcnt_irq_ctrl.sv
module qcnt_irq_ctrl
  import qcnt_irq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 4
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  input  logic [NUM_CH-1:0] evCarry,
  input  logic [NUM_CH-1:0] evBorrow,
  input  logic [NUM_CH-1:0] evCompare,
  input  logic [NUM_CH-1:0] evIndex,
  input  logic [NUM_CH-1:0] indexLevel,
  input  logic [NUM_CH-1:0] cableOk,
  output logic [NUM_CH-1:0] abEnable,
  output logic [NUM_CH-1:0] presetIdxN,
  output logic [NUM_CH-1:0] cableDetEn,
  output logic              countRun,
  output logic              counterClear,
  output logic              irq
);

  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  ctlStrobe_t      strb;
  logic [CH_W-1:0] chanIdx;

  qcnt_irq_ctl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_ctl (
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .strb    (strb),
    .chanIdx (chanIdx)
  );

  qcnt_irq_dp #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .chanIdx      (chanIdx),
    .rdAddr       (rdAddr),
    .rdData       (rdData),
    .evCarry      (evCarry),
    .evBorrow     (evBorrow),
    .evCompare    (evCompare),
    .evIndex      (evIndex),
    .indexLevel   (indexLevel),
    .cableOk      (cableOk),
    .abEnable     (abEnable),
    .presetIdxN   (presetIdxN),
    .cableDetEn   (cableDetEn),
    .countRun     (countRun),
    .counterClear (counterClear),
    .irq          (irq)
  );

endmodule

// File: tb/tb_qcnt_irq_ctrl.sv
module tb_qcnt_irq_ctrl;

  localparam int N = 8;
  localparam logic [3:0] A_STAT = 4'd8, A_CMD = 4'd9, A_MASK = 4'd10,
                         A_LVL = 4'd11, A_CABLE = 4'd12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [3:0] rdAddr = '0;
  logic [7:0] rdData;
  logic [N-1:0] evCarry = '0, evBorrow = '0, evCompare = '0, evIndex = '0;
  logic [N-1:0] indexLevel = '0, cableOk = '0;
  logic [N-1:0] abEnable, presetIdxN, cableDetEn;
  logic countRun, counterClear, irq;

  int checks = 0;
  int fails = 0;
  logic [7:0] v;

  always #2 clk = ~clk;

  qcnt_irq_ctrl #(.NUM_CH(N), .ADDR_W(4)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .evCarry(evCarry), .evBorrow(evBorrow),
    .evCompare(evCompare), .evIndex(evIndex), .indexLevel(indexLevel),
    .cableOk(cableOk), .abEnable(abEnable), .presetIdxN(presetIdxN),
    .cableDetEn(cableDetEn), .countRun(countRun), .counterClear(counterClear),
    .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    rdAddr = a;
    #0.5;
    d = rdData;
  endtask

  // kind: 0 carry, 1 borrow, 2 compare, 3 index
  task automatic pulse(input int ch, input int kind);
    @(negedge clk);
    case (kind)
      0: evCarry[ch] = 1'b1;
      1: evBorrow[ch] = 1'b1;
      2: evCompare[ch] = 1'b1;
      default: evIndex[ch] = 1'b1;
    endcase
    @(negedge clk);
    evCarry = '0; evBorrow = '0; evCompare = '0; evIndex = '0;
  endtask

  function automatic logic expHit(input int code, input int kind);
    case (code)
      0: return kind == 0;
      1: return kind == 2;
      2: return (kind == 0) || (kind == 1);
      default: return kind == 3;
    endcase
  endfunction

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int c = 0; c < N; c++) begin
      rd(4'(c), v); chk("R1 ioc reset", v, 0);
    end
    rd(A_MASK, v);  chk("R1 mask reset", v, 0);
    rd(A_STAT, v);  chk("R1 pending reset", v, 0);
    rd(A_CMD, v);   chk("R1 cmd reset", v, 0);
    rd(A_CABLE, v); chk("R1 cable reset", v, 8'hFF);
    chk("R1 outputs reset", {irq, countRun, counterClear}, 0);

    // R2 control byte storage and outputs
    wr(4'd2, 8'hFF);
    rd(4'd2, v); chk("R2 ioc upper bits zero", v, 8'h1F);
    chk("R2 abEnable", abEnable, 8'h04);
    chk("R2 presetIdxN", presetIdxN, 8'h04);
    wr(4'd2, 8'h01);
    chk("R2 ab only", {abEnable, presetIdxN}, {8'h04, 8'h00});

    // R3/R4/R11 sweep of channel x trigger code x source
    wr(A_MASK, 8'hFF);
    for (int ch = 0; ch < N; ch++)
      for (int code = 0; code < 4; code++)
        for (int kind = 0; kind < 4; kind++) begin
          wr(4'(ch), 8'(code << 3));
          wr(A_CMD, 8'h04);
          pulse(ch, kind);
          rd(A_STAT, v);
          chk("R3 trigger select", v, expHit(code, kind) ? 8'(1 << ch) : 8'h00);
          chk("R11 irq follows pending", irq, expHit(code, kind));
        end

    // R4 sticky and accumulating
    for (int c = 0; c < N; c++) wr(4'(c), 8'h00);
    wr(A_CMD, 8'h04);
    pulse(1, 0);
    pulse(5, 0);
    repeat (5) @(negedge clk);
    rd(A_STAT, v); chk("R4 sticky pending", v, 8'h22);

    // R5 mask gating
    wr(A_CMD, 8'h04);
    wr(A_MASK, 8'h08);
    @(negedge clk); evCarry = '1; @(negedge clk); evCarry = '0;
    rd(A_STAT, v); chk("R5 single mask bit", v, 8'h08);
    wr(A_CMD, 8'h04);
    wr(A_MASK, 8'h00);
    @(negedge clk); evCarry = '1; @(negedge clk); evCarry = '0;
    rd(A_STAT, v); chk("R5 mask all off", v, 8'h00);
    chk("R11 irq low", irq, 0);

    // R7 same-cycle arm and event while armed: event kept
    wr(A_MASK, 8'hFF);
    pulse(6, 0);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = A_CMD; wrData = 8'h04; evCarry[3] = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; evCarry = '0;
    rd(A_STAT, v); chk("R7 clear with same-cycle event", v, 8'h08);
    rd(A_CMD, v); chk("R7 armed readback", v, 8'h04);
    chk("R7 countRun high", countRun, 1);

    // R6 reset command
    wr(A_CMD, 8'h01);
    chk("R6 clear pulse high", counterClear, 1);
    chk("R6 countRun low", countRun, 0);
    @(posedge clk); #1;
    chk("R6 clear pulse one cycle", counterClear, 0);
    rd(A_STAT, v); chk("R6 pending kept", v, 8'h08);
    rd(A_CMD, v); chk("R6 disarmed readback", v, 8'h00);
    pulse(0, 0);
    rd(A_STAT, v); chk("R6 events ignored", v, 8'h08);

    // R7 arm while disarmed with same-cycle event: event dropped
    @(negedge clk);
    wrEn = 1'b1; wrAddr = A_CMD; wrData = 8'h04; evCarry[2] = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; evCarry = '0;
    rd(A_STAT, v); chk("R7 unarmed same-cycle event", v, 8'h00);

    // R8 other command values
    pulse(4, 0);
    for (int k = 0; k < 256; k++) begin
      if (k == 1 || k == 4) continue;
      wr(A_CMD, 8'(k));
      if (counterClear) begin checks++; fails++; $display("FAIL R8 clear pulse on %h actual=1 expected=0", k); end
    end
    rd(A_STAT, v); chk("R8 pending unchanged", v, 8'h10);
    rd(A_CMD, v); chk("R8 arm unchanged", v, 8'h04);
    chk("R8 countRun unchanged", countRun, 1);

    // R9 cable enable and readback
    cableOk = 8'h00;
    rd(A_CABLE, v); chk("R9 disabled ignores faults", v, 8'hFF);
    wr(A_CABLE, 8'hF0);
    cableOk = 8'h5A;
    rd(A_CABLE, v); chk("R9 fault readback", v, 8'hFA);
    chk("R9 detect enable", cableDetEn, 8'h0F);

    // R10 live index levels
    indexLevel = 8'hA5;
    rd(A_LVL, v); chk("R10 index level", v, 8'hA5);
    indexLevel = 8'h3C;
    rd(A_LVL, v); chk("R10 index level change", v, 8'h3C);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule